// File: doc/BRIEF.md
# Ramped Serial-Loaded Stereo Attenuator

This block scales a stereo stream of 20-bit two's complement samples by a gain factor. A three-wire serial port sets the gain: a data line, a shift clock and a latch strobe. An 11-bit word shifted in MSB first and then latched becomes the gain target. Full scale is 1024, which means unity gain, and 0 means silence.

The applied gain never jumps to a new value. A running gain register moves toward the target by a fixed step on every sample strobe. If a new target arrives while a ramp is still under way, the ramp turns toward the new target. A mute input sets the effective target to zero, so the output fades out smoothly. When mute is released, the gain climbs back to the stored target. Both channels always share the same running gain. The serial lines are asynchronous to the system clock and are resynchronized inside the block.

Top module: `ramped_attenuator`

## Requirements
- R1: The serial port synchronizes its three lines to the system clock. On each rising edge of `ser_clk` it shifts `ser_data` into an 11-bit shift register, MSB first. After eleven shifts, the first bit sent is bit 10 of the word.
- R2: A rising edge of `ser_latch` copies the shift register into the target register. Any word above 1024 is clamped to 1024. Shifting without a latch leaves the target, and therefore the gain, unchanged.
- R3: While `rst_n` is low, `out_valid` is 0 and both outputs are 0. After reset, the target and the running gain both start at 1024 (unity), and mute takes effect only from the `mute` pin.
- R4: On each `in_valid` strobe, the running gain moves 2 toward the effective target. It never passes the target: if it is 1 away, it lands exactly on the target.
- R5: If the target changes during a ramp, the next strobe already steps toward the new target.
- R6: While `mute` is 1, the effective target is 0. A full fade from 1024 to 0 takes exactly 512 strobes, and after it the outputs are 0. When `mute` returns to 0, the gain ramps back to the stored target.
- R7: Each output equals floor(sample × gain / 1024), saturated to the 20-bit range. The gain used is the running gain before the update made at the same strobe. Both channels use the same gain.
- R8: `out_valid` is high in exactly the cycle after each `in_valid` cycle. Between strobes the gain holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mute | input | 1 | Fade to silence while high |
| ser_data | input | 1 | Serial gain word data |
| ser_clk | input | 1 | Serial shift clock, rising edge active |
| ser_latch | input | 1 | Transfers the shifted word on its rising edge |
| in_valid | input | 1 | Sample strobe |
| in_left | input | 20 | Left input sample, two's complement |
| in_right | input | 20 | Right input sample, two's complement |
| out_valid | output | 1 | Scaled sample pair is valid |
| out_left | output | 20 | Scaled left sample |
| out_right | output | 20 | Scaled right sample |

## Verification
A wrong running gain shows up on the very next strobe. The bench feeds a sample of 500 × 1024, so the output is exactly 500 times the gain and every step of a ramp can be read off directly. A faulty target register, a bad clamp or a lost serial bit appears only when ramping starts. It shows within the first strobe after the latch, because the first step points the wrong way or the ramp stops at the wrong value. Errors in ramp length or overshoot show at the end of a ramp, for example when a mute fade does not reach zero at exactly strobe 512.

// File: rtl/att_pkg.sv
package att_pkg;
  localparam int SAMPLE_W = 20;
  localparam int WORD_W   = 11;
  localparam int FRAC_W   = 10;
  localparam int RAMP_STEP = 2;

  typedef enum logic [1:0] {
    RAMP_HOLD = 2'd0,
    RAMP_UP   = 2'd1,
    RAMP_DOWN = 2'd2
  } ramp_dir_e;
endpackage

// File: rtl/att_serial_port.sv
module att_serial_port
  import att_pkg::*;
#(
  parameter int WORD   = WORD_W,
  parameter int FRAC   = FRAC_W,
  localparam int GW    = FRAC + 1
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_data,
  input  logic          ser_clk,
  input  logic          ser_latch,
  output logic [GW-1:0] target,
  output logic          shift_evt,
  output logic          load_evt
);
  localparam logic [GW-1:0] UNITY = GW'(1 << FRAC);

  // three flops per line: two for metastability, one for edge detection
  logic [2:0]      d_sync, c_sync, l_sync;
  logic [WORD-1:0] shreg;

  function automatic logic [GW-1:0] clamp_word(input logic [WORD-1:0] w);
    if (w > WORD'(UNITY)) return UNITY;
    return GW'(w);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_sync <= '0;
      c_sync <= '0;
      l_sync <= '0;
    end else begin
      d_sync <= {d_sync[1:0], ser_data};
      c_sync <= {c_sync[1:0], ser_clk};
      l_sync <= {l_sync[1:0], ser_latch};
    end
  end

  assign shift_evt = c_sync[1] & ~c_sync[2];
  assign load_evt  = l_sync[1] & ~l_sync[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      target <= UNITY;
    end else begin
      if (shift_evt) shreg  <= {shreg[WORD-2:0], d_sync[1]};
      if (load_evt)  target <= clamp_word(shreg);
    end
  end

  p_target_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    target <= UNITY);
  p_target_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(target));
endmodule

// File: rtl/att_gain_ramp.sv
module att_gain_ramp
  import att_pkg::*;
#(
  parameter int FRAC = FRAC_W,
  parameter int STEP = RAMP_STEP,
  localparam int GW  = FRAC + 1
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic          mute,
  input  logic [GW-1:0] target,
  output logic [GW-1:0] gain,
  output ramp_dir_e     dir
);
  localparam logic [GW-1:0] UNITY = GW'(1 << FRAC);
  localparam logic [GW-1:0] STEPV = GW'(STEP);

  logic [GW-1:0] aim;

  function automatic logic [GW-1:0] next_gain(input logic [GW-1:0] cur,
                                               input logic [GW-1:0] goal);
    if (cur < goal) return (goal - cur > STEPV) ? cur + STEPV : goal;
    if (cur > goal) return (cur - goal > STEPV) ? cur - STEPV : goal;
    return cur;
  endfunction

  assign aim = mute ? '0 : target;

  always_comb begin
    if (gain < aim)      dir = RAMP_UP;
    else if (gain > aim) dir = RAMP_DOWN;
    else                 dir = RAMP_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gain <= UNITY;
    else if (strobe) gain <= next_gain(gain, aim);
  end

  p_step_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (int'(gain) <= int'($past(gain)) + STEP) &&
               (int'(gain) + STEP >= int'($past(gain))));
  p_no_overshoot_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && dir == RAMP_UP) |=> gain <= $past(aim));
  p_no_overshoot_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && dir == RAMP_DOWN) |=> gain >= $past(aim));
  p_mute_fades_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && mute && gain != '0) |=> gain < $past(gain));
  p_hold_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(gain));
endmodule

// File: rtl/att_scale.sv
module att_scale
  import att_pkg::*;
#(
  parameter int DW   = SAMPLE_W,
  parameter int FRAC = FRAC_W,
  localparam int GW  = FRAC + 1,
  localparam int PW  = DW + GW + 1
)(
  input  logic signed [DW-1:0] sample,
  input  logic        [GW-1:0] gain,
  output logic signed [DW-1:0] scaled
);
  localparam logic signed [PW-1:0] MAXV = PW'((64'sd1 <<< (DW - 1)) - 1);
  localparam logic signed [PW-1:0] MINV = -PW'(64'sd1 <<< (DW - 1));

  function automatic logic signed [DW-1:0] apply_gain(input logic signed [DW-1:0] s,
                                                      input logic [GW-1:0] g);
    logic signed [PW-1:0] prod;
    prod = (PW'(s) * $signed({1'b0, g})) >>> FRAC;
    if (prod > MAXV) return DW'(MAXV);
    if (prod < MINV) return DW'(MINV);
    return DW'(prod);
  endfunction

  assign scaled = apply_gain(sample, gain);
endmodule

// File: rtl/ramped_attenuator.sv
module ramped_attenuator
  import att_pkg::*;
#(
  parameter int DW   = SAMPLE_W,
  parameter int WORD = WORD_W,
  parameter int FRAC = FRAC_W,
  parameter int STEP = RAMP_STEP,
  localparam int GW  = FRAC + 1,
  localparam int NCH = 2
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mute,
  input  logic                 ser_data,
  input  logic                 ser_clk,
  input  logic                 ser_latch,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_left,
  input  logic signed [DW-1:0] in_right,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_left,
  output logic signed [DW-1:0] out_right
);
  logic [GW-1:0] target, gain;
  logic          shift_evt, load_evt;
  ramp_dir_e     dir;

  logic signed [DW-1:0] ch_in  [NCH];
  logic signed [DW-1:0] ch_out [NCH];
  logic signed [DW-1:0] ch_q   [NCH];

  att_serial_port #(.WORD(WORD), .FRAC(FRAC)) u_port (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
    .ser_latch(ser_latch), .target(target), .shift_evt(shift_evt),
    .load_evt(load_evt)
  );

  att_gain_ramp #(.FRAC(FRAC), .STEP(STEP)) u_ramp (
    .clk(clk), .rst_n(rst_n), .strobe(in_valid), .mute(mute),
    .target(target), .gain(gain), .dir(dir)
  );

  assign ch_in[0] = in_left;
  assign ch_in[1] = in_right;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    att_scale #(.DW(DW), .FRAC(FRAC)) u_scale (
      .sample(ch_in[c]), .gain(gain), .scaled(ch_out[c])
    );
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ch_q[c] <= '0;
      else if (in_valid) ch_q[c] <= ch_out[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  assign out_left  = ch_q[0];
  assign out_right = ch_q[1];

  p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_channels_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_left == in_right) |=> out_left == out_right);
  p_silent_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && gain == '0) |=> (out_left == '0 && out_right == '0));
endmodule

// File: tb/tb_ramped_attenuator.sv
module tb_ramped_attenuator;
  localparam int K = 512000;  // 500 * 1024: output equals 500 * gain

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mute = 1'b0;
  logic ser_data = 1'b0, ser_clk = 1'b0, ser_latch = 1'b0;
  logic in_valid = 1'b0;
  logic signed [19:0] in_left = '0, in_right = '0;
  logic out_valid;
  logic signed [19:0] out_left, out_right;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_target = 1024;
  int m_gain   = 1024;
  bit m_mute   = 1'b0;

  int    q_l[$];
  int    q_r[$];
  string q_req[$];

  always #2 clk = ~clk;

  ramped_attenuator dut (
    .clk(clk), .rst_n(rst_n), .mute(mute), .ser_data(ser_data),
    .ser_clk(ser_clk), .ser_latch(ser_latch), .in_valid(in_valid),
    .in_left(in_left), .in_right(in_right), .out_valid(out_valid),
    .out_left(out_left), .out_right(out_right)
  );

  function automatic int ref_scale(int s, int g);
    longint p, q;
    p = longint'(s) * longint'(g);
    q = p / 1024;
    if (p < 0 && (p % 1024) != 0) q = q - 1;
    if (q > 524287) q = 524287;
    if (q < -524288) q = -524288;
    return int'(q);
  endfunction

  function automatic int ref_step(int cur, int aim);
    if (cur < aim) return (aim - cur > 2) ? cur + 2 : aim;
    if (cur > aim) return (cur - aim > 2) ? cur - 2 : aim;
    return cur;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send(int l, int r, string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_left  = 20'(l);
    in_right = 20'(r);
    q_l.push_back(ref_scale(l, m_gain));
    q_r.push_back(ref_scale(r, m_gain));
    q_req.push_back(req);
    m_gain = ref_step(m_gain, m_mute ? 0 : m_target);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic shift_word(int w);
    for (int i = 10; i >= 0; i--) begin
      ser_data = w[i];
      repeat (4) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic latch_word;
    ser_latch = 1'b1;
    repeat (4) @(negedge clk);
    ser_latch = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic load(int w);
    shift_word(w);
    latch_word();
    m_target = (w > 1024) ? 1024 : w;
  endtask

  task automatic set_mute(bit m);
    @(negedge clk);
    mute = m;
    m_mute = m;
  endtask

  // monitor: pops expected pairs as results appear
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_l.size() == 0) begin
        check(1'b0, "R8", "unexpected out_valid", 1, 0);
      end else begin
        int el, er;
        string rq;
        el = q_l.pop_front();
        er = q_r.pop_front();
        rq = q_req.pop_front();
        check(int'(out_left) == el, rq, "left", int'(out_left), el);
        check(int'(out_right) == er, rq, "right", int'(out_right), er);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R3: reset silences the outputs even with strobes present
    in_valid = 1'b1;
    in_left  = 20'sd1000;
    in_right = -20'sd1000;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R3", "out_valid in reset", int'(out_valid), 0);
    check(out_left == 0 && out_right == 0, "R3", "outputs in reset", int'(out_left), 0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3 R7: unity gain after reset, extremes and rounding
    send(524287, -524288, "R7");
    send(-1, 3, "R7");
    send(K, -K, "R3");

    // R8: idle cycles give no valid, gain holds
    repeat (5) @(negedge clk);
    check(out_valid == 1'b0, "R8", "idle out_valid", int'(out_valid), 0);
    send(K, -K, "R8");

    // R1 R2 R4: load 1000, ramp down by 2 and settle
    load(1000);
    for (int i = 0; i < 16; i++) send(K, -K, "R4");
    // R4: odd target one above, lands exactly
    load(1001);
    for (int i = 0; i < 3; i++) send(K, -K, "R4");
    // R1: bit order, 0x155 = 341
    load(341);
    for (int i = 0; i < 340; i++) send(K, 12345, "R1");
    // R5: retarget mid ramp
    load(100);
    for (int i = 0; i < 40; i++) send(K, -K, "R5");
    load(900);
    for (int i = 0; i < 420; i++) send(K, -777, "R5");
    // R2: shifting without latch changes nothing
    shift_word(20);
    for (int i = 0; i < 4; i++) send(K, -K, "R2");
    // R2: clamp 2047 to 1024
    load(2047);
    for (int i = 0; i < 70; i++) send(K, -K, "R2");
    check(m_gain == 1024, "R2", "model gain after clamp", m_gain, 1024);

    // R6: mute fade of exactly 512 strobes
    set_mute(1'b1);
    for (int i = 0; i < 511; i++) send(K, -K, "R6");
    send(K, -K, "R6");
    send(K, -K, "R6");
    @(negedge clk);
    check(out_left == 0 && out_right == 0, "R6", "silent after 512", int'(out_left), 0);
    // R6: release returns to stored target
    set_mute(1'b0);
    for (int i = 0; i < 514; i++) send(K, -K, "R6");
    @(negedge clk);
    check(out_left == 20'sd512000, "R6", "unity after release", int'(out_left), K);

    repeat (4) @(negedge clk);
    check(q_l.size() == 0, "R8", "scoreboard drained", q_l.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule